// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block gathers up to eight interrupt request lines, latches them into a pending register and gates them through a software mask. It then raises one interrupt line toward the processor. A fixed priority picks the winner, with line 0 highest. While the processor acknowledges, the block presents a vector: a programmed base that is a multiple of eight, with the winning line number in its low three bits. The acknowledged line then moves into an in-service register. That in-service bit holds off any request of equal or lower priority until software writes an end-of-interrupt command or the automatic end-of-interrupt mode clears it.

Software reaches the block through two write addresses, a command port and a data port. Outside an initialization sequence, the data port reads and writes the mask. A command with bit 4 set starts a new initialization. After it come a base word, a cascade word and a mode word on the data port. The first command says whether the cascade word and the mode word are part of the sequence. The cascade word and the mode word together set whether the block acts as master or slave. The inputs can be edge-triggered or level-triggered.

Top module: `irqc_top`

## Requirements
- R1: After reset the interrupt output is low, the mask reads 0xFF (every line masked), the block reports master role, and the inputs are edge-triggered.
- R2: With no initialization in progress, a data-port write (bus_sel=1) loads the mask (bit i = 1 masks line i), and bus_rdata shows the new mask from the next cycle.
- R3: In edge mode a line becomes pending only on a low-to-high transition. A line held high after its acknowledge does not request again.
- R4: In level mode (command bit 3) the pending bit follows the input level every cycle. A request withdrawn before acknowledge leaves the interrupt output low.
- R5: int_out is high only if some pending line is unmasked and has a higher priority than every in-service line. A masked pending line is delivered once it is unmasked.
- R6: Line 0 has the highest priority and line 7 the lowest. While int_out is high, int_vec is {base[7:3], index of the lowest-numbered qualifying line}.
- R7: An int_ack pulse while int_out is high clears that line's pending bit and sets its in-service bit. int_out then stays low unless a line of higher priority is pending, and such a line is still delivered (nesting).
- R8: A command write of exactly 0x20 clears only the highest-priority in-service bit.
- R9: With mode-word bit 1 set (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R10: A command write with bit 4 set clears the mask, pending and in-service registers, keeps int_out low until the sequence ends, and expects data words in a fixed order. The base comes first, with its low 3 bits dropped. The cascade word comes next unless command bit 1 (single) is set. The mode word comes last, and only if command bit 0 is set.
- R11: The block is master when it is single, when the mode word has bit 3 clear, or when mode bits 3:2 are 11. It is slave when mode bits 3:2 are 10. casc_cfg shows the whole cascade word for a master and only its low 3 bits (the slave identity) for a slave. mode_cfg shows mode bits 4:0.
- R12: A command write with bit 4 clear and a value other than 0x20 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_IN | Interrupt request lines |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Data-port read value (mask) |
| int_out | output | 1 | Interrupt request to processor |
| int_ack | input | 1 | One-cycle acknowledge from processor |
| int_vec | output | 8 | Vector valid while int_out is high |
| is_master | output | 1 | Cascade role: 1 = master |
| casc_cfg | output | 8 | Stored cascade wiring or slave identity |
| mode_cfg | output | 5 | Stored mode word |

## Verification
The bench builds the block with its defaults: N_IN = 8 and a reset mask of all ones. That makes all eight priority levels and the full 3-bit vector field visible. It also makes the masked-at-reset state observable. Directed sequences cover three initialization shapes (single with mode word, cascaded slave in level mode with automatic end-of-interrupt, cascaded master without mode word). Random traffic then mixes edges, level changes, acknowledges, end-of-interrupt commands, stray commands and re-initialization. This random phase reaches nesting depths and collisions between acknowledge and end-of-interrupt that the directed sequences do not.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {SEQ_IDLE, SEQ_BASE, SEQ_CASC, SEQ_MODE} seq_t;

   localparam logic [7:0] CMD_NS_EOI = 8'h20;

   // command word bit positions
   localparam int C_START  = 4;
   localparam int C_MODEON = 0;
   localparam int C_SINGLE = 1;
   localparam int C_LEVEL  = 3;

   // mode word bit positions
   localparam int M_AEOI = 1;
   localparam int M_ROLE = 2;
   localparam int M_BUF  = 3;
   localparam int MODE_W = 5;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
   import irqc_pkg::*;
#(
   parameter int N_IN = 8,
   parameter logic [N_IN-1:0] RST_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_sel,
   input  logic [7:0]        bus_wdata,
   output logic [N_IN-1:0]   mask_q,
   output logic [4:0]        base_q,
   output logic [7:0]        casc_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              single_q,
   output logic              level_q,
   output logic              busy,
   output logic              init_go,
   output logic              eoi_go
);
   seq_t seq_q;
   logic need_mode_q;
   logic cmd_wr, dat_wr;

   assign cmd_wr  = bus_wr & ~bus_sel;
   assign dat_wr  = bus_wr & bus_sel;
   assign init_go = cmd_wr & bus_wdata[C_START];
   assign eoi_go  = cmd_wr & (bus_wdata == CMD_NS_EOI);
   assign busy    = (seq_q != SEQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q       <= SEQ_IDLE;
         mask_q      <= RST_MASK;
         base_q      <= '0;
         casc_q      <= '0;
         mode_q      <= '0;
         single_q    <= 1'b1;
         level_q     <= 1'b0;
         need_mode_q <= 1'b0;
      end else if (init_go) begin
         seq_q       <= SEQ_BASE;
         mask_q      <= '0;
         casc_q      <= '0;
         mode_q      <= '0;
         need_mode_q <= bus_wdata[C_MODEON];
         single_q    <= bus_wdata[C_SINGLE];
         level_q     <= bus_wdata[C_LEVEL];
      end else if (dat_wr) begin
         unique case (seq_q)
            SEQ_IDLE: mask_q <= bus_wdata[N_IN-1:0];
            SEQ_BASE: begin
               base_q <= bus_wdata[7:3];
               if (!single_q)        seq_q <= SEQ_CASC;
               else if (need_mode_q) seq_q <= SEQ_MODE;
               else                  seq_q <= SEQ_IDLE;
            end
            SEQ_CASC: begin
               casc_q <= bus_wdata;
               seq_q  <= need_mode_q ? SEQ_MODE : SEQ_IDLE;
            end
            SEQ_MODE: begin
               mode_q <= bus_wdata[MODE_W-1:0];
               seq_q  <= SEQ_IDLE;
            end
            default: seq_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
   parameter int N_IN = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] req,
   input  logic            level,
   input  logic            clr_all,
   input  logic [N_IN-1:0] ack_clr,
   output logic [N_IN-1:0] pend_q
);
   for (genvar g = 0; g < N_IN; g++) begin : g_line
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q    <= 1'b0;
            pend_q[g] <= 1'b0;
         end else begin
            prev_q <= req[g];
            if (clr_all)    pend_q[g] <= 1'b0;
            else if (level) pend_q[g] <= req[g];
            else            pend_q[g] <= (pend_q[g] & ~ack_clr[g]) | (req[g] & ~prev_q);
         end
      end
   end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int N_IN = 8,
   localparam int IW = $clog2(N_IN)
) (
   input  logic [N_IN-1:0] pend,
   input  logic [N_IN-1:0] mask,
   input  logic [N_IN-1:0] isr,
   output logic            cand_ok,
   output logic [IW-1:0]   cand_idx,
   output logic [N_IN-1:0] cand_1h,
   output logic [N_IN-1:0] isr_top
);
   logic [N_IN-1:0] allow, elig;

   always_comb begin
      logic seen;
      seen = 1'b0;
      for (int j = 0; j < N_IN; j++) begin
         seen     = seen | isr[j];
         allow[j] = ~seen;
      end
      elig = pend & ~mask & allow;
   end

   always_comb begin
      cand_ok  = 1'b0;
      cand_idx = '0;
      for (int j = N_IN - 1; j >= 0; j--) begin
         if (elig[j]) begin
            cand_ok  = 1'b1;
            cand_idx = IW'(j);
         end
      end
   end

   assign cand_1h = elig & (~elig + 1'b1);
   assign isr_top = isr & (~isr + 1'b1);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int N_IN = 8,
   parameter logic [N_IN-1:0] RST_MASK = '1,
   localparam int IW = $clog2(N_IN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN-1:0]   irq_in,
   input  logic              bus_wr,
   input  logic              bus_sel,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              int_out,
   input  logic              int_ack,
   output logic [7:0]        int_vec,
   output logic              is_master,
   output logic [7:0]        casc_cfg,
   output logic [MODE_W-1:0] mode_cfg
);
   if (N_IN < 2 || N_IN > 8 || (N_IN & (N_IN - 1)) != 0) begin : g_bad_n
      $error("irqc_top: N_IN must be 2, 4 or 8");
   end

   logic [N_IN-1:0]   mask_q, pend_q, isr_q, cand_1h, isr_top;
   logic [4:0]        base_q;
   logic [7:0]        casc_q;
   logic [MODE_W-1:0] mode_q;
   logic              single_q, level_q, init_busy, init_go, eoi_go;
   logic              cand_ok, ack_go, aeoi;
   logic [IW-1:0]     cand_idx;

   irqc_cfg #(.N_IN(N_IN), .RST_MASK(RST_MASK)) u_cfg (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .mask_q(mask_q), .base_q(base_q),
      .casc_q(casc_q), .mode_q(mode_q), .single_q(single_q),
      .level_q(level_q), .busy(init_busy), .init_go(init_go), .eoi_go(eoi_go)
   );

   irqc_pend #(.N_IN(N_IN)) u_pend (
      .clk(clk), .rst_n(rst_n), .req(irq_in), .level(level_q),
      .clr_all(init_go), .ack_clr(ack_go ? cand_1h : '0), .pend_q(pend_q)
   );

   irqc_prio #(.N_IN(N_IN)) u_prio (
      .pend(pend_q), .mask(mask_q), .isr(isr_q), .cand_ok(cand_ok),
      .cand_idx(cand_idx), .cand_1h(cand_1h), .isr_top(isr_top)
   );

   assign aeoi    = mode_q[M_AEOI];
   assign int_out = cand_ok & ~init_busy;
   assign ack_go  = int_ack & int_out;
   assign int_vec = {base_q, 3'(cand_idx)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
      end else if (init_go) begin
         isr_q <= '0;
      end else begin
         isr_q <= (isr_q & ~(eoi_go ? isr_top : '0))
                | ((ack_go && !aeoi) ? cand_1h : '0);
      end
   end

   assign bus_rdata = 8'(mask_q);
   assign is_master = single_q | ~mode_q[M_BUF] | mode_q[M_ROLE];
   assign casc_cfg  = is_master ? casc_q : {5'b0, casc_q[2:0]};
   assign mode_cfg  = mode_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int N_IN = 8,
   localparam int IW = $clog2(N_IN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_wr,
   input logic            bus_sel,
   input logic [7:0]      bus_wdata,
   input logic            int_out,
   input logic            int_ack,
   input logic [7:0]      int_vec,
   input logic [N_IN-1:0] pend,
   input logic [N_IN-1:0] mask,
   input logic [N_IN-1:0] isr,
   input logic            aeoi,
   input logic            in_init
);
   AST_INIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      in_init |-> !int_out); // R10

   AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> ((pend & ~mask) != '0)); // R5

   AST_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_out && !aeoi && !bus_wr) |=> isr[$past(int_vec[IW-1:0])]); // R7

   AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_sel && bus_wdata == 8'h20 && !int_ack && isr != '0)
      |=> ($countones(isr) + 1 == $countones($past(isr)))); // R8

   AST_AEOI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && aeoi && !bus_wr) |=> (isr == $past(isr))); // R9
endmodule

bind irqc_top irqc_checker #(.N_IN(N_IN)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
   .bus_wdata(bus_wdata), .int_out(int_out), .int_ack(int_ack),
   .int_vec(int_vec), .pend(pend_q), .mask(mask_q), .isr(isr_q),
   .aeoi(aeoi), .in_init(init_busy)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic       wr = 1'b0, sel = 1'b0, ack = 1'b0;
   logic [7:0] wd = '0;
   logic [7:0] rdata, vec, casc;
   logic       intr, master;
   logic [4:0] mode;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #5ns clk = ~clk;

   irqc_top u_irqc_top (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_wr(wr), .bus_sel(sel),
      .bus_wdata(wd), .bus_rdata(rdata), .int_out(intr), .int_ack(ack),
      .int_vec(vec), .is_master(master), .casc_cfg(casc), .mode_cfg(mode)
   );

   // reference state, built from the requirements
   int         m_seq;
   logic [7:0] m_mask, m_base, m_casc, m_pend, m_prev, m_isr;
   logic [4:0] m_mode;
   logic       m_single, m_level, m_need;

   function automatic logic [3:0] ref_pick();
      for (int i = 0; i < 8; i++) begin
         int lowbits = (1 << (i + 1)) - 1;
         if (m_pend[i] && !m_mask[i] && ((m_isr & 8'(lowbits)) == 8'h00))
            return {1'b1, 3'(i)};
      end
      return 4'h0;
   endfunction

   function automatic logic ref_int();
      logic [3:0] p = ref_pick();
      return p[3] && (m_seq == 0);
   endfunction

   function automatic logic ref_master();
      return m_single || !m_mode[3] || m_mode[2];
   endfunction

   task automatic model_reset();
      m_seq = 0; m_mask = 8'hFF; m_base = 0; m_casc = 0; m_pend = 0;
      m_prev = 0; m_isr = 0; m_mode = 0; m_single = 1; m_level = 0; m_need = 0;
   endtask

   task automatic model_step();
      logic [3:0] p = ref_pick();
      logic ackn = ack && ref_int();
      logic init = wr && !sel && wd[4];
      logic eoi = wr && !sel && (wd == 8'h20);
      logic [7:0] abit = ackn ? (8'h01 << p[2:0]) : 8'h00;
      logic [7:0] nisr = m_isr;
      if (eoi) begin
         for (int i = 0; i < 8; i++) if (nisr[i]) begin nisr[i] = 1'b0; break; end
      end
      if (ackn && !m_mode[1]) nisr = nisr | abit;
      if (init) nisr = 0;
      if (init) m_pend = 0;
      else if (m_level) m_pend = irq;
      else m_pend = (m_pend & ~abit) | (irq & ~m_prev);
      m_prev = irq;
      m_isr = nisr;
      if (init) begin
         m_seq = 1; m_mask = 0; m_casc = 0; m_mode = 0;
         m_need = wd[0]; m_single = wd[1]; m_level = wd[3];
      end else if (wr && sel) begin
         case (m_seq)
            0: m_mask = wd;
            1: begin m_base = {wd[7:3], 3'b0}; m_seq = !m_single ? 2 : (m_need ? 3 : 0); end
            2: begin m_casc = wd; m_seq = m_need ? 3 : 0; end
            default: begin m_mode = wd[4:0]; m_seq = 0; end
         endcase
      end
   endtask

   task automatic check(string tag, logic ok, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; ack = 1'b0;
   endtask

   task automatic cmd(logic [7:0] d);  sel = 1'b0; wr = 1'b1; wd = d; tick(); endtask
   task automatic dat(logic [7:0] d);  sel = 1'b1; wr = 1'b1; wd = d; tick(); endtask
   task automatic do_ack();            ack = 1'b1; tick(); endtask

   task automatic expect_int(string tag, logic e_int, logic [7:0] e_vec);
      check(tag, intr == e_int, intr, e_int);
      if (e_int) check(tag, vec == e_vec, vec, e_vec);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 int", intr == 1'b0, intr, 0);
      check("R1 mask", rdata == 8'hFF, rdata, 8'hFF);
      check("R1 role", master == 1'b1, master, 1);

      // R2 mask write
      dat(8'hA5);
      check("R2 mask", rdata == 8'hA5, rdata, 8'hA5);

      // scenario: single, edge, mode word follows
      cmd(8'h13);
      check("R10 mask cleared", rdata == 8'h00, rdata, 0);
      dat(8'h25);
      expect_int("R10 busy", 1'b0, 8'h00);
      dat(8'h01);
      check("R11 single master", master == 1'b1, master, 1);
      check("R11 mode", mode == 5'h01, mode, 1);
      irq[5] = 1'b1; tick();
      expect_int("R6 base low bits dropped", 1'b1, 8'h25);
      irq[2] = 1'b1; tick();
      expect_int("R6 priority", 1'b1, 8'h22);
      do_ack();
      expect_int("R7 lower blocked", 1'b0, 8'h00);
      irq[0] = 1'b1; tick();
      expect_int("R7 nesting", 1'b1, 8'h20);
      do_ack();
      cmd(8'h20);
      expect_int("R8 only top cleared", 1'b0, 8'h00);
      cmd(8'h20);
      expect_int("R8 second eoi", 1'b1, 8'h25);
      do_ack();
      cmd(8'h20);
      expect_int("R3 held high no rerequest", 1'b0, 8'h00);
      dat(8'h02);
      irq[1] = 1'b1; tick();
      expect_int("R5 masked", 1'b0, 8'h00);
      dat(8'h00);
      expect_int("R5 unmasked", 1'b1, 8'h21);
      do_ack();
      cmd(8'h0A);
      check("R12 mask kept", rdata == 8'h00, rdata, 0);
      irq[3] = 1'b1; tick();
      expect_int("R12 isr kept", 1'b0, 8'h00);
      cmd(8'h20);
      expect_int("R8 release", 1'b1, 8'h23);
      do_ack();
      cmd(8'h20);
      irq = '0; tick();

      // scenario: cascaded slave, level, automatic eoi
      cmd(8'h19);
      irq[3] = 1'b1;
      dat(8'h48);
      expect_int("R10 silent in sequence", 1'b0, 8'h00);
      dat(8'h02);
      dat(8'h0A);
      check("R11 slave", master == 1'b0, master, 0);
      check("R11 slave id", casc == 8'h02, casc, 2);
      expect_int("R4 level", 1'b1, 8'h4B);
      irq[3] = 1'b0; tick();
      expect_int("R4 withdrawn", 1'b0, 8'h00);
      irq[3] = 1'b1; tick();
      do_ack();
      expect_int("R9 still level", 1'b1, 8'h4B);
      irq[3] = 1'b0; irq[6] = 1'b1; tick();
      expect_int("R9 no in-service", 1'b1, 8'h4E);
      irq = '0; tick();

      // scenario: cascaded master, no mode word
      cmd(8'h10);
      dat(8'h30);
      dat(8'h04);
      check("R11 master", master == 1'b1, master, 1);
      check("R11 wiring", casc == 8'h04, casc, 4);
      dat(8'h3C);
      check("R10 sequence length", rdata == 8'h3C, rdata, 8'h3C);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] p;
         int r;
         p = ref_pick();
         check("R5 int", intr == ref_int(), intr, ref_int());
         if (ref_int()) check("R6 vec", vec == {m_base[7:3], p[2:0]}, vec, {m_base[7:3], p[2:0]});
         check("R2 rdata", rdata == m_mask, rdata, m_mask);
         check("R11 role", master == ref_master(), master, ref_master());
         irq = irq ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
         ack = ($urandom % 4) == 0;
         r = $urandom % 100;
         if (r < 6)       begin sel = 1'b0; wr = 1'b1; wd = 8'h20; end
         else if (r < 9)  begin sel = 1'b1; wr = 1'b1; wd = 8'($urandom) & 8'h1F; end
         else if (r < 10) begin sel = 1'b0; wr = 1'b1; wd = 8'($urandom) & 8'hEF; end
         else if (r < 11) begin sel = 1'b0; wr = 1'b1; wd = 8'h10 | (8'($urandom) & 8'h0B); end
         model_step();
         @(posedge clk);
         @(negedge clk);
         wr = 1'b0; ack = 1'b0;
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule